// File: doc/BRIEF.md
# Delayed-Effect Mode Register

This block holds a processor mode word whose bits steer other logic only after a per-bit delay. It keeps two copies of the word. The architectural copy is what a read returns, and it always holds the newest write on the cycle after that write. The effective copy is what the controlled logic sees, and each of its bits catches up with the architectural bit after a latency. That latency depends on the bit position and on the path that changed it.

Three paths write the word:
- a full load that replaces every bit with immediate data;
- a restore that replaces every bit with a word popped from a status stack;
- a single-bit command that sets or clears one bit by index.

Full loads and restores share one latency table. The select bits for the alternate address-register bank and for bit-reversed addressing wait three cycles. One sticky-overflow bit is immediate. Every other bit waits one cycle. The single-bit command is immediate for every bit. A newer write to a bit cancels an older write to that bit that is still pending.

Top module: `modelat_reg`

## Requirements
- R1: While `rstN` is low, and after it is released with no writes, `archValue` and `effValue` both equal `RESET_VAL` (default 0). A reset discards any pending effective update.
- R2: A full load (`loadEn`) replaces every bit of `archValue` with `loadData`, seen on the cycle after the clock edge that samples it, whatever the bit's latency.
- R3: A restore (`popEn`) replaces `archValue` with `popData` in the same way. When `popEn` and `loadEn` are both high, `popData` wins.
- R4: A single-bit command (`cmdEn`) writes `cmdVal` to bit `cmdIdx`. It shows in both `archValue` and `effValue` on the next cycle. The command wins over a load or restore in the same cycle for that bit. The command leaves all other bits alone. An index of `W` or more (10 to 15 by default) changes nothing.
- R5: For the three-cycle bits (`SLOW_MASK`, default bits 1 and 6), a load or restore sampled at edge k changes `effValue` at edge k+3. The old value stays visible after edges k, k+1 and k+2.
- R6: For the immediate bit (`ZERO_MASK`, default bit 3), a load or restore changes `effValue` at the same edge as `archValue`.
- R7: Every other bit (default bits 0, 2, 4, 5, 7, 8, 9) changes `effValue` at edge k+1 after a load or restore sampled at edge k.
- R8: A newer write to a bit replaces any pending older write to that bit. The newer value takes effect within its own latency, and the older value never appears in `effValue`, even when its delay would have run out on the edge of the newer write.
- R9: With no write, `archValue` holds its value. After `SLOW_LAT` cycles with no write, `effValue` equals `archValue`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Full load strobe |
| loadData | input | W | Word for a full load |
| popEn | input | 1 | Stack restore strobe |
| popData | input | W | Word from the status stack |
| cmdEn | input | 1 | Single-bit command strobe |
| cmdIdx | input | $clog2(W) | Bit index for the command |
| cmdVal | input | 1 | Value written by the command |
| archValue | output | W | Readable word, newest write |
| effValue | output | W | Word seen by the controlled logic, delayed per bit |

## Verification
The bench runs sequences in which writes land while older writes to the same bits are still pending. A design that queued writes rather than replacing them would let a stale value surface in `effValue` one or two cycles after a command had already set the bit. The bench also lands a write on the exact edge where an older three-cycle write expires. A design that let the expiry win on that edge would show the old value for several cycles.

Restores that arrive together with a load, and commands that arrive together with a load or restore, check the merge priority bit by bit. An out-of-range index must leave the word unchanged; a decoder that wrapped the index would flip a real bit. A reset issued while updates are pending must not let them land once reset is released.

// File: rtl/modelat_pkg.sv
package modelat_pkg;

  // Latency class chosen by the control for one bit of one write
  typedef enum logic [1:0] {
    LAT_NOW  = 2'd0,
    LAT_ONE  = 2'd1,
    LAT_SLOW = 2'd2
  } latSel_e;

  // Strobe bundle from control to datapath, one per bit
  typedef struct packed {
    logic    hit;
    logic    val;
    latSel_e sel;
  } bitUpd_t;

endpackage

// File: rtl/modelat_ctrl.sv
module modelat_ctrl
  import modelat_pkg::*;
#(
  parameter int            W         = 10,
  parameter logic [W-1:0]  SLOW_MASK = 10'b00_0100_0010,
  parameter logic [W-1:0]  ZERO_MASK = 10'b00_0000_1000,
  localparam int           IW        = $clog2(W)
) (
  input  logic                 loadEn,
  input  logic [W-1:0]         loadData,
  input  logic                 popEn,
  input  logic [W-1:0]         popData,
  input  logic                 cmdEn,
  input  logic [IW-1:0]        cmdIdx,
  input  logic                 cmdVal,
  output bitUpd_t [W-1:0]      upd
);

  // Whole-word write: a restore beats a load
  logic         wordHit;
  logic [W-1:0] wordVal;

  assign wordHit = loadEn | popEn;
  assign wordVal = popEn ? popData : loadData;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      upd[i].hit = wordHit;
      upd[i].val = wordVal[i];
      if (SLOW_MASK[i])      upd[i].sel = LAT_SLOW;
      else if (ZERO_MASK[i]) upd[i].sel = LAT_NOW;
      else                   upd[i].sel = LAT_ONE;
      // Single-bit command overrides the word write for its bit
      if (cmdEn && (int'(cmdIdx) == i)) begin
        upd[i].hit = 1'b1;
        upd[i].val = cmdVal;
        upd[i].sel = LAT_NOW;
      end
    end
  end

endmodule

// File: rtl/modelat_bit.sv
module modelat_bit
  import modelat_pkg::*;
#(
  parameter int   SLOW_LAT = 3,
  parameter logic RST_VAL  = 1'b0,
  localparam int  CW       = $clog2(SLOW_LAT + 1)
) (
  input  logic    clk,
  input  logic    rstN,
  input  bitUpd_t upd,
  output logic    archBit,
  output logic    effBit
);

  logic [CW-1:0] remain;
  logic          pendVal;
  logic [CW-1:0] startCnt;

  always_comb begin
    case (upd.sel)
      LAT_NOW: startCnt = '0;
      LAT_ONE: startCnt = CW'(1);
      default: startCnt = CW'(SLOW_LAT);
    endcase
  end

  // One pending write per bit; a new write restarts the countdown
  always_ff @(posedge clk) begin
    if (!rstN) begin
      archBit <= RST_VAL;
      effBit  <= RST_VAL;
      pendVal <= RST_VAL;
      remain  <= '0;
    end else if (upd.hit) begin
      archBit <= upd.val;
      pendVal <= upd.val;
      remain  <= startCnt;
      if (startCnt == '0) effBit <= upd.val;
    end else if (remain != '0) begin
      remain <= remain - CW'(1);
      if (remain == CW'(1)) effBit <= pendVal;
    end
  end

endmodule

// File: rtl/modelat_datapath.sv
module modelat_datapath
  import modelat_pkg::*;
#(
  parameter int           W         = 10,
  parameter int           SLOW_LAT  = 3,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  bitUpd_t [W-1:0] upd,
  output logic [W-1:0]    archValue,
  output logic [W-1:0]    effValue
);

  for (genvar g = 0; g < W; g++) begin : gBit
    modelat_bit #(
      .SLOW_LAT (SLOW_LAT),
      .RST_VAL  (RESET_VAL[g])
    ) uBit (
      .clk     (clk),
      .rstN    (rstN),
      .upd     (upd[g]),
      .archBit (archValue[g]),
      .effBit  (effValue[g])
    );
  end

endmodule

// File: rtl/modelat_reg.sv
module modelat_reg
  import modelat_pkg::*;
#(
  parameter int           W         = 10,
  parameter int           SLOW_LAT  = 3,
  parameter logic [W-1:0] SLOW_MASK = 10'b00_0100_0010,
  parameter logic [W-1:0] ZERO_MASK = 10'b00_0000_1000,
  parameter logic [W-1:0] RESET_VAL = '0,
  localparam int          IW        = $clog2(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadEn,
  input  logic [W-1:0]  loadData,
  input  logic          popEn,
  input  logic [W-1:0]  popData,
  input  logic          cmdEn,
  input  logic [IW-1:0] cmdIdx,
  input  logic          cmdVal,
  output logic [W-1:0]  archValue,
  output logic [W-1:0]  effValue
);

  bitUpd_t [W-1:0] upd;

  modelat_ctrl #(
    .W         (W),
    .SLOW_MASK (SLOW_MASK),
    .ZERO_MASK (ZERO_MASK)
  ) uCtrl (
    .loadEn   (loadEn),
    .loadData (loadData),
    .popEn    (popEn),
    .popData  (popData),
    .cmdEn    (cmdEn),
    .cmdIdx   (cmdIdx),
    .cmdVal   (cmdVal),
    .upd      (upd)
  );

  modelat_datapath #(
    .W         (W),
    .SLOW_LAT  (SLOW_LAT),
    .RESET_VAL (RESET_VAL)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .upd       (upd),
    .archValue (archValue),
    .effValue  (effValue)
  );

endmodule

// File: rtl/modelat_chk.sv
module modelat_chk #(
  parameter int           W         = 10,
  parameter int           SLOW_LAT  = 3,
  parameter logic [W-1:0] ZERO_MASK = 10'b00_0000_1000,
  localparam int          IW        = $clog2(W),
  localparam int          QW        = $clog2(SLOW_LAT + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          loadEn,
  input logic [W-1:0]  loadData,
  input logic          popEn,
  input logic [W-1:0]  popData,
  input logic          cmdEn,
  input logic [IW-1:0] cmdIdx,
  input logic          cmdVal,
  input logic [W-1:0]  archValue,
  input logic [W-1:0]  effValue
);

  logic          anyWrite;
  logic [QW-1:0] quietCnt;

  assign anyWrite = loadEn | popEn | (cmdEn && (int'(cmdIdx) < W));

  always_ff @(posedge clk) begin
    if (!rstN)                         quietCnt <= QW'(SLOW_LAT);
    else if (anyWrite)                 quietCnt <= '0;
    else if (quietCnt < QW'(SLOW_LAT)) quietCnt <= quietCnt + QW'(1);
  end

  // R2
  load_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && !popEn && !cmdEn) |=> archValue == $past(loadData));

  // R3
  pop_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !cmdEn) |=> archValue == $past(popData));

  // R6
  zero_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((effValue ^ archValue) & ZERO_MASK) == '0);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyWrite |=> $stable(archValue));

  // R9
  settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (quietCnt == QW'(SLOW_LAT)) |-> effValue == archValue);

  for (genvar g = 0; g < W; g++) begin : gCmd
    // R4
    cmd_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cmdEn && (int'(cmdIdx) == g)) |=>
        (archValue[g] == $past(cmdVal)) && (effValue[g] == $past(cmdVal)));
  end

endmodule

bind modelat_reg modelat_chk #(
  .W         (W),
  .SLOW_LAT  (SLOW_LAT),
  .ZERO_MASK (ZERO_MASK)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .loadEn    (loadEn),
  .loadData  (loadData),
  .popEn     (popEn),
  .popData   (popData),
  .cmdEn     (cmdEn),
  .cmdIdx    (cmdIdx),
  .cmdVal    (cmdVal),
  .archValue (archValue),
  .effValue  (effValue)
);

// File: tb/tb_modelat_reg.sv
module tb_modelat_reg;

  localparam int W  = 10;
  localparam int IW = 4;
  localparam int NV = 19;

  typedef struct packed {
    logic          ld;
    logic [W-1:0]  ldD;
    logic          pop;
    logic [W-1:0]  popD;
    logic          cmd;
    logic [IW-1:0] idx;
    logic          cv;
    logic [W-1:0]  expA;
    logic [W-1:0]  expE;
  } vec_t;

  // Slow bits 1,6 (3 cycles); bit 3 immediate; others 1 cycle. Expectations after each edge.
  localparam vec_t VEC [NV] = '{
    '{1'b1, 10'h3FF, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h3FF, 10'h008}, // 0  R2 R6
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h3FF, 10'h3BD}, // 1  R7
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h3FF, 10'h3BD}, // 2  R5
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h3FF, 10'h3FF}, // 3  R5
    '{1'b1, 10'h000, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h000, 10'h3F7}, // 4  R2 R6
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b1, 4'd6,  1'b1, 10'h040, 10'h042}, // 5  R4 R7
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h040, 10'h042}, // 6  R8
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h040, 10'h040}, // 7  R8 R5
    '{1'b1, 10'h155, 1'b1, 10'h2AA, 1'b0, 4'd0,  1'b0, 10'h2AA, 10'h048}, // 8  R3
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b1, 4'd12, 1'b1, 10'h2AA, 10'h2E8}, // 9  R4 R7
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h2AA, 10'h2E8}, // 10 R9
    '{1'b1, 10'h000, 1'b0, 10'h000, 1'b1, 4'd1,  1'b1, 10'h002, 10'h2E2}, // 11 R4 R8
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h002, 10'h042}, // 12 R7
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h002, 10'h042}, // 13 R8
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h002, 10'h002}, // 14 R5
    '{1'b0, 10'h000, 1'b1, 10'h3FF, 1'b1, 4'd9,  1'b0, 10'h1FF, 10'h00A}, // 15 R3 R4
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h1FF, 10'h1BF}, // 16 R7
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h1FF, 10'h1BF}, // 17 R5
    '{1'b0, 10'h000, 1'b0, 10'h000, 1'b0, 4'd0,  1'b0, 10'h1FF, 10'h1FF}  // 18 R5
  };

  localparam string TAG [NV] = '{
    "R2 R6", "R7", "R5", "R5", "R2 R6", "R4 R7", "R8", "R8 R5", "R3", "R4 R7",
    "R9", "R4 R8", "R7", "R8", "R5", "R3 R4", "R7", "R5", "R5"
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic          loadEn, popEn, cmdEn, cmdVal;
  logic [W-1:0]  loadData, popData;
  logic [IW-1:0] cmdIdx;
  logic [W-1:0]  archValue, effValue;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  modelat_reg dut (
    .clk       (clk),
    .rstN      (rstN),
    .loadEn    (loadEn),
    .loadData  (loadData),
    .popEn     (popEn),
    .popData   (popData),
    .cmdEn     (cmdEn),
    .cmdIdx    (cmdIdx),
    .cmdVal    (cmdVal),
    .archValue (archValue),
    .effValue  (effValue)
  );

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic setIn(input logic ld, input logic [W-1:0] ldD,
                       input logic pp, input logic [W-1:0] ppD,
                       input logic cm, input logic [IW-1:0] ix, input logic cv);
    loadEn = ld; loadData = ldD; popEn = pp; popData = ppD;
    cmdEn = cm; cmdIdx = ix; cmdVal = cv;
  endtask

  task automatic idle();
    setIn(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0);
  endtask

  initial begin
    rstN = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    chk("R1", "arch in reset", archValue, 10'h000);
    chk("R1", "eff in reset",  effValue,  10'h000);
    rstN = 1'b1;

    // Vector table: drive at a falling edge, check at the next one
    for (int i = 0; i < NV; i++) begin
      setIn(VEC[i].ld, VEC[i].ldD, VEC[i].pop, VEC[i].popD,
            VEC[i].cmd, VEC[i].idx, VEC[i].cv);
      @(negedge clk);
      chk(TAG[i], $sformatf("row %0d arch", i), archValue, VEC[i].expA);
      chk(TAG[i], $sformatf("row %0d eff",  i), effValue,  VEC[i].expE);
    end
    idle();

    // R9: quiet period settles and holds
    repeat (4) @(negedge clk);
    chk("R9", "arch quiet", archValue, 10'h1FF);
    chk("R9", "eff quiet",  effValue,  10'h1FF);

    // R1: reset with writes pending
    setIn(1'b1, 10'h000, 1'b0, '0, 1'b0, '0, 1'b0);
    @(negedge clk);
    idle();
    rstN = 1'b0;
    @(negedge clk);
    chk("R1", "arch reset mid-flight", archValue, 10'h000);
    chk("R1", "eff reset mid-flight",  effValue,  10'h000);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "arch after release", archValue, 10'h000);
    chk("R1", "eff after release",  effValue,  10'h000);

    // R7: one-cycle bit 0
    setIn(1'b1, 10'h001, 1'b0, '0, 1'b0, '0, 1'b0);
    @(negedge clk);
    idle();
    chk("R7", "arch bit0 load", archValue, 10'h001);
    chk("R7", "eff bit0 edge k", effValue, 10'h000);
    @(negedge clk);
    chk("R7", "eff bit0 edge k+1", effValue, 10'h001);

    // R5: three-cycle bit 1, with bit 0 falling at k+1
    setIn(1'b1, 10'h002, 1'b0, '0, 1'b0, '0, 1'b0);
    @(negedge clk);
    idle();
    chk("R5", "arch slow load", archValue, 10'h002);
    chk("R5", "eff edge k",     effValue,  10'h001);
    @(negedge clk);
    chk("R5", "eff edge k+1",   effValue,  10'h000);
    @(negedge clk);
    chk("R5", "eff edge k+2",   effValue,  10'h000);
    @(negedge clk);
    chk("R5", "eff edge k+3",   effValue,  10'h002);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule